// File: doc/BRIEF.md
# External Interrupt Edge Qualifier

This block conditions three asynchronous interrupt pins before they reach a processor core. The first pin is a non-maskable request that is active low. The other two are user interrupts whose active edge is set by configuration. Each pin is synchronized and watched for its active edge. A request is accepted only if the pin still shows the post-edge level one clock after the edge was first seen. An accepted request sets a sticky pending flag, which stays set until the core acknowledges that source.

The core sees registered request flags. A global mask bit gates the two user requests but never the non-maskable one. When configuration enables it, the second user pin can also serve as an external start-of-conversion trigger for an analog converter. In that use, each accepted edge on the pin also gives a one-cycle strobe. All pins are idle high after reset.

Top module: `ext_irq_qualifier`

## Requirements
- R1: After reset, `nmi_req`, `usr_req` and `soc_strobe` are low, both user polarities select the falling edge, and the conversion trigger is disabled.
- R2: If `nmi_n_pin` is first sampled low at clock edge k and is still low at edge k+1, after having been high at edge k-1, then `nmi_req` is high from edge k+4 onward.
- R3: A low level on `nmi_n_pin` that is sampled at only one clock edge produces no request.
- R4: `nmi_req` follows its pending flag whatever the value of `gmask`.
- R5: Configuration bit 0 sets the active edge of `usr_pin[0]` and bit 1 sets that of `usr_pin[1]`. A value of 0 selects falling and 1 selects rising. An edge in the other direction produces no request.
- R6: A user edge is accepted only if the pin holds the new level at the clock edge after the one that first sampled it. The accepted edge raises the matching `usr_req` bit at edge k+4, with k counted as in R2. A level sampled for a single cycle is ignored.
- R7: Each `usr_req` bit is the registered AND of its pending flag and the inverse of `gmask`. A request that arrives while masked stays pending and appears one edge after `gmask` falls.
- R8: A pending flag is cleared when its acknowledge input is high at an edge, unless a new edge is accepted in the same cycle. The request output then falls one edge later.
- R9: If an acknowledge and a newly accepted edge for the same source coincide at a clock edge, the flag stays set.
- R10: When configuration bit 2 is 1, each accepted edge on `usr_pin[1]` gives a one-cycle `soc_strobe` at edge k+3. When the bit is 0, no strobe is produced. The user request is raised in both cases.
- R11: Changing a polarity bit while the pin is static produces no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_n_pin | input | 1 | Asynchronous non-maskable pin, active low |
| usr_pin | input | 2 | Asynchronous user interrupt pins |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 3 | {trigger enable, user1 polarity, user0 polarity} |
| gmask | input | 1 | Global mask for user requests, 1 = masked |
| ack_nmi | input | 1 | Acknowledge for the non-maskable source |
| ack_usr | input | 2 | Acknowledges for the user sources |
| nmi_req | output | 1 | Registered non-maskable request |
| usr_req | output | 2 | Registered user requests after masking |
| soc_strobe | output | 1 | One-cycle start-of-conversion strobe |

## Verification
A pin level first sampled at edge k reaches the pending flag at edge k+3. The request outputs follow at edge k+4, and the conversion strobe appears at edge k+3. An acknowledge or a change of mask shows at the outputs one edge after it is sampled. The bench's reference model tracks pin history, pending flags and registered outputs edge by edge, with these same delays. It is compared with the outputs at every falling clock edge, half a period after the outputs update. The directed checks wait a fixed number of falling edges, counted from these delays, before they sample an output.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_NMI = 0;
  localparam int SRC_U0  = 1;
  localparam int SRC_U1  = 2;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  typedef struct packed {
    logic      soc_en;
    edge_pol_e pol_u1;
    edge_pol_e pol_u0;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= {STAGES{RST_VAL}};
    else     ff <= {ff[STAGES-2:0], din};
  end

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/irq_edge_qual.sv
module irq_edge_qual #(
  parameter int HOLD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic act_lvl,
  output logic qual
);
  localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          prev;
  logic          armed;
  logic [CW-1:0] hcnt;
  logic          edge_hit;
  logic          at_act;

  assign at_act   = (lvl == act_lvl);
  assign edge_hit = at_act && (prev != act_lvl);
  assign qual     = armed && at_act && (hcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b1;
      armed <= 1'b0;
      hcnt  <= '0;
    end else begin
      prev <= lvl;
      if (armed) begin
        if (!at_act || qual) armed <= 1'b0;
        else                 hcnt  <= hcnt + 1'b1;
      end else if (edge_hit) begin
        armed <= 1'b1;
        hcnt  <= '0;
      end
    end
  end

  AST_QUAL_HELD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    qual |-> $past(lvl == act_lvl)); // R6
  AST_ARM_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(lvl == act_lvl) && $past(prev != act_lvl)); // R5
endmodule

// File: rtl/irq_pend.sv
module irq_pend (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)      pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (ack) pend <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> pend); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && !set) |=> !pend); // R8
endmodule

// File: rtl/ext_irq_qualifier.sv
module ext_irq_qualifier
  import irq_qual_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_n_pin,
  input  logic [1:0]       usr_pin,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             gmask,
  input  logic             ack_nmi,
  input  logic [1:0]       ack_usr,
  output logic             nmi_req,
  output logic [1:0]       usr_req,
  output logic             soc_strobe
);
  cfg_t               cfg_q;
  logic [NUM_SRC-1:0] pin_v, lvl_v, act_v, ack_v, qual_v, pend_v;

  assign pin_v = {usr_pin, nmi_n_pin};
  assign ack_v = {ack_usr, ack_nmi};
  assign act_v = {logic'(cfg_q.pol_u1), logic'(cfg_q.pol_u0), 1'b0};

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst(rst), .din(pin_v[g]), .dout(lvl_v[g]));
    irq_edge_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
      .clk(clk), .rst(rst), .lvl(lvl_v[g]), .act_lvl(act_v[g]), .qual(qual_v[g]));
    irq_pend u_pend (
      .clk(clk), .rst(rst), .set(qual_v[g]), .ack(ack_v[g]), .pend(pend_v[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_req    <= 1'b0;
      usr_req    <= '0;
      soc_strobe <= 1'b0;
    end else begin
      nmi_req    <= pend_v[SRC_NMI];
      usr_req    <= pend_v[SRC_U1:SRC_U0] & {2{~gmask}};
      soc_strobe <= qual_v[SRC_U1] & cfg_q.soc_en;
    end
  end

  AST_NMI_IGNORES_MASK: assert property (@(posedge clk) disable iff (rst)
    (gmask && pend_v[SRC_NMI]) |=> nmi_req); // R4
  AST_MASK_BLOCKS_USER: assert property (@(posedge clk) disable iff (rst)
    gmask |=> (usr_req == 2'b00)); // R7
  AST_SOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    soc_strobe |=> !soc_strobe); // R10
  AST_SOC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    soc_strobe |-> $past(cfg_q.soc_en)); // R10
  AST_SOC_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    soc_strobe |-> pend_v[SRC_U1]); // R10
endmodule

// File: tb/ext_irq_qualifier_tb.sv
module ext_irq_qualifier_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmi_n_pin = 1'b1;
  logic [1:0] usr_pin = 2'b11;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = 3'b000;
  logic       gmask = 1'b0;
  logic       ack_nmi = 1'b0;
  logic [1:0] ack_usr = 2'b00;
  logic       nmi_req;
  logic [1:0] usr_req;
  logic       soc_strobe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_qualifier u_dut (
    .clk(clk), .rst(rst), .nmi_n_pin(nmi_n_pin), .usr_pin(usr_pin),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .gmask(gmask),
    .ack_nmi(ack_nmi), .ack_usr(ack_usr), .nmi_req(nmi_req),
    .usr_req(usr_req), .soc_strobe(soc_strobe));

  int    vec = 0;
  int    miss = 0;
  int    soc_cnt = 0;
  string phase = "R1";

  // behavioural reference model: pin histories, newest sample at index 0
  logic [3:0] mh [3];
  logic [2:0] m_pend;
  logic [2:0] m_cfg;
  logic       m_nmi;
  logic [1:0] m_usr;
  logic       m_soc;

  always @(posedge clk) begin
    logic [2:0] pins, ackv, act, setv;
    pins = {usr_pin, nmi_n_pin};
    ackv = {ack_usr, ack_nmi};
    if (rst) begin
      for (int s = 0; s < 3; s++) mh[s] = 4'hF;
      m_pend = '0; m_cfg = '0; m_nmi = 0; m_usr = '0; m_soc = 0;
    end else begin
      act = {m_cfg[1], m_cfg[0], 1'b0};
      for (int s = 0; s < 3; s++)
        setv[s] = (mh[s][1] == act[s]) && (mh[s][2] == act[s]) && (mh[s][3] != act[s]);
      m_nmi = m_pend[0];
      m_usr = gmask ? 2'b00 : m_pend[2:1];
      m_soc = setv[2] && m_cfg[2];
      for (int s = 0; s < 3; s++)
        m_pend[s] = setv[s] | (m_pend[s] & ~ackv[s]);
      if (cfg_we) m_cfg = cfg_wdata;
      for (int s = 0; s < 3; s++) mh[s] = {mh[s][2:0], pins[s]};
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vec++;
      if ({nmi_req, usr_req, soc_strobe} !== {m_nmi, m_usr, m_soc}) begin
        miss++;
        $display("FAIL %s: outputs {nmi,usr,soc} got %b expected %b",
                 phase, {nmi_req, usr_req, soc_strobe}, {m_nmi, m_usr, m_soc});
      end
      if (soc_strobe) soc_cnt++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    vec++;
    if (got != exp) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] v);
    cfg_wdata = v; cfg_we = 1'b1; step(1); cfg_we = 1'b0;
  endtask

  task automatic ack_pulse(input logic n, input logic [1:0] u);
    ack_nmi = n; ack_usr = u; step(1); ack_nmi = 1'b0; ack_usr = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    miss++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(2);
    phase = "R1";
    chk("R1 nmi_req", int'(nmi_req), 0);
    chk("R1 usr_req", int'(usr_req), 0);
    chk("R1 soc_strobe", int'(soc_strobe), 0);

    phase = "R2";
    nmi_n_pin = 1'b0; step(5);
    chk("R2 nmi_req", int'(nmi_req), 1);
    step(2); nmi_n_pin = 1'b1; step(2);

    phase = "R8";
    ack_pulse(1'b1, 2'b00); step(1);
    chk("R8 nmi_req after ack", int'(nmi_req), 0);

    phase = "R3";
    nmi_n_pin = 1'b0; step(1); nmi_n_pin = 1'b1; step(6);
    chk("R3 nmi short pulse", int'(nmi_req), 0);

    phase = "R4";
    gmask = 1'b1; nmi_n_pin = 1'b0; step(5);
    chk("R4 nmi under mask", int'(nmi_req), 1);
    nmi_n_pin = 1'b1; ack_pulse(1'b1, 2'b00); step(2); gmask = 1'b0;

    phase = "R5";
    usr_pin[0] = 1'b0; step(5);
    chk("R5 usr0 falling", int'(usr_req[0]), 1);
    ack_pulse(1'b0, 2'b01); step(1);
    usr_pin[0] = 1'b1; step(6);
    chk("R5 usr0 rising ignored", int'(usr_req[0]), 0);
    wr_cfg(3'b001); step(2);
    usr_pin[0] = 1'b0; step(6);
    chk("R5 usr0 falling ignored when rising set", int'(usr_req[0]), 0);
    usr_pin[0] = 1'b1; step(5);
    chk("R5 usr0 rising accepted", int'(usr_req[0]), 1);
    ack_pulse(1'b0, 2'b01); step(2);

    phase = "R11";
    wr_cfg(3'b000); step(6);
    chk("R11 pol change to falling, pin static", int'(usr_req[0]), 0);
    wr_cfg(3'b001); step(6);
    chk("R11 pol change to rising, pin static", int'(usr_req[0]), 0);
    wr_cfg(3'b000); step(2);

    phase = "R6";
    usr_pin[1] = 1'b0; step(1); usr_pin[1] = 1'b1; step(6);
    chk("R6 usr1 glitch ignored", int'(usr_req[1]), 0);
    usr_pin[1] = 1'b0; step(4);
    chk("R6 usr1 not yet at k+3", int'(usr_req[1]), 0);
    step(1);
    chk("R6 usr1 at k+4", int'(usr_req[1]), 1);
    ack_pulse(1'b0, 2'b10); usr_pin[1] = 1'b1; step(4);

    phase = "R7";
    gmask = 1'b1; usr_pin[1] = 1'b0; step(6);
    chk("R7 usr1 masked", int'(usr_req[1]), 0);
    gmask = 1'b0; step(2);
    chk("R7 usr1 after unmask", int'(usr_req[1]), 1);
    ack_pulse(1'b0, 2'b10); usr_pin[1] = 1'b1; step(4);

    phase = "R9";
    usr_pin[0] = 1'b0; step(5);
    usr_pin[0] = 1'b1; step(3);
    usr_pin[0] = 1'b0; step(3);
    ack_pulse(1'b0, 2'b01); step(3);
    chk("R9 ack with coincident set", int'(usr_req[0]), 1);
    ack_pulse(1'b0, 2'b01); usr_pin[0] = 1'b1; step(3);
    chk("R8 usr0 cleared", int'(usr_req[0]), 0);

    phase = "R10";
    soc_cnt = 0;
    usr_pin[1] = 1'b0; step(6);
    chk("R10 no strobe when disabled", soc_cnt, 0);
    ack_pulse(1'b0, 2'b10); usr_pin[1] = 1'b1; step(3);
    wr_cfg(3'b100); step(2);
    soc_cnt = 0;
    usr_pin[1] = 1'b0; step(8);
    chk("R10 one strobe when enabled", soc_cnt, 1);
    chk("R10 usr1 request raised", int'(usr_req[1]), 1);
    ack_pulse(1'b0, 2'b10); usr_pin[1] = 1'b1; step(4);

    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule